// File: doc/BRIEF.md
# SOF-Locked Oscillator Trim Controller

This block keeps an on-chip free-running oscillator close enough to its nominal rate for full-speed USB. It runs entirely on the oscillator clock and uses the start-of-frame strobes of the USB link, already brought into that clock domain, as a 1 ms timing reference. It counts oscillator cycles between two strobes, compares the count with a nominal target (oscillator frequency divided by 1000, 48000 by default) and nudges an 8-bit trim code by one step per frame. A trim step moves the oscillator by about 0.1 percent. The code-to-frequency relation is non-linear and varies from one device to the next, so the block searches by measurement alone and computes no code from a formula.

An untrimmed oscillator can be up to 2 percent off, which is about twenty steps, and the loop walks that distance one frame at a time. A small deadband stops the code from dithering around the target. A lock flag reports that the measured rate has stayed within the 2500 ppm USB tolerance for several frames in a row. An error flag reports that the loop wants to move past either end of the trim range. A missing strobe makes the block drop the current interval and leave the trim code alone.

Top module: `osc_trim_ctrl`

## Requirements
- R1: After reset the trim code is TRIM_INIT (128 by default), and locked and trim_err are 0.
- R2: The measured count is the number of clock cycles between two consecutive sampled sof pulses. A pulse 2000 cycles after the previous one gives 2000. The first pulse after reset, or after enable rises, only starts an interval and changes no output.
- R3: With deadband D = floor(TARGET_CNT*500/1e6) (0.05 percent), a count above TARGET_CNT + D lowers the trim code by one.
- R4: A count below TARGET_CNT - D raises the trim code by one. A count within D of the target leaves the code unchanged.
- R5: The trim code stops at 0 and at 2^TRIM_W-1 and never wraps. trim_err is set on a frame that asks for a step past either limit, and is cleared by the next evaluated frame that does not.
- R6: If no pulse arrives within TARGET_CNT*3/2 cycles of the interval start, the interval is discarded and trim_code and locked do not change. The next pulse starts a new interval. An interval of exactly TARGET_CNT*3/2 cycles is still evaluated.
- R7: A frame is in tolerance when |count - TARGET_CNT| <= floor(TARGET_CNT*2500/1e6). locked rises on the 4th consecutive in-tolerance frame, not earlier.
- R8: locked clears on the first evaluated frame that is out of tolerance.
- R9: While enable is 0, sof pulses are ignored, trim_code holds, and locked and trim_err are 0.
- R10: trim_code moves by at most one step per frame. It changes only on the clock edge that samples the closing sof pulse and is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock being trimmed |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the trim loop when 1 |
| sof | input | 1 | One-cycle start-of-frame strobe, already synchronised |
| trim_code | output | TRIM_W | Trim code driven to the oscillator |
| locked | output | 1 | Rate within USB tolerance for the last 4 frames |
| trim_err | output | 1 | Last frame asked for a step beyond the trim range |

## Verification
A wrong interval count shows up on trim_code at the first evaluated frame after the fault. The bench therefore drives intervals one cycle either side of every deadband, tolerance and timeout edge, and reads the code right after the closing edge. A broken streak counter or arming flag shows within four frames, as locked rising one frame early or late, or as a code step on a pulse that should only have started an interval. A closed loop, in which the bench derives each interval from the current code through a non-linear oscillator model, shows that the search settles on the right code and reports lock.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_UP   = 2'd1,
    ACT_DOWN = 2'd2
  } trim_act_e;

  // Part of a target count given in parts per million (floor).
  function automatic int ppm_span(input int target, input int ppm);
    return int'((longint'(target) * longint'(ppm)) / 64'sd1000000);
  endfunction

  // Fast oscillator (count too high) steps down, slow steps up.
  function automatic trim_act_e pick_action(input int count, input int target,
                                            input int band);
    if (count > target + band) return ACT_DOWN;
    if (count < target - band) return ACT_UP;
    return ACT_HOLD;
  endfunction

  function automatic logic within_tol(input int count, input int target,
                                      input int tol);
    int diff;
    diff = count - target;
    if (diff < 0) diff = -diff;
    return (diff <= tol);
  endfunction

endpackage

// File: rtl/sof_interval_counter.sv
module sof_interval_counter #(
  parameter int TARGET = 48000,
  parameter int CNT_W  = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             sof,
  output logic             meas_valid,
  output logic [CNT_W-1:0] meas_count,
  output logic             timeout_evt
);
  localparam int               TIMEOUT = TARGET + TARGET / 2;
  localparam logic [CNT_W-1:0] TMO_C   = CNT_W'(TIMEOUT);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             armed;

  assign meas_valid  = enable && armed && sof;
  assign meas_count  = cnt;
  assign timeout_evt = enable && armed && !sof && (cnt >= TMO_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (!enable) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (sof) begin
      cnt   <= ONE_C;
      armed <= 1'b1;
    end else if (timeout_evt) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (armed) begin
      cnt   <= cnt + ONE_C;
    end
  end

  // R6
  timeout_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> !armed);

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TMO_C);

  // R9
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !armed && !meas_valid);

endmodule

// File: rtl/trim_stepper.sv
module trim_stepper
  import osc_trim_pkg::*;
#(
  parameter int TARGET       = 48000,
  parameter int CNT_W        = 17,
  parameter int TRIM_W       = 8,
  parameter int TRIM_INIT    = 128,
  parameter int DEADBAND_PPM = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              meas_valid,
  input  logic [CNT_W-1:0]  meas_count,
  output logic [TRIM_W-1:0] trim,
  output logic              sat_err
);
  localparam int                BAND     = ppm_span(TARGET, DEADBAND_PPM);
  localparam logic [TRIM_W-1:0] TRIM_MAX = '1;
  localparam logic [TRIM_W-1:0] STEP     = TRIM_W'(1);

  trim_act_e act;
  logic      at_top, at_bot;

  assign act    = pick_action(int'(meas_count), TARGET, BAND);
  assign at_top = (trim == TRIM_MAX);
  assign at_bot = (trim == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim    <= TRIM_W'(TRIM_INIT);
      sat_err <= 1'b0;
    end else if (!enable) begin
      sat_err <= 1'b0;
    end else if (meas_valid) begin
      case (act)
        ACT_UP: begin
          sat_err <= at_top;
          if (!at_top) trim <= trim + STEP;
        end
        ACT_DOWN: begin
          sat_err <= at_bot;
          if (!at_bot) trim <= trim - STEP;
        end
        default: sat_err <= 1'b0;
      endcase
    end
  end

  // R10
  trim_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_valid |=> $stable(trim));

  // R10
  trim_one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |=> (trim == $past(trim)) || (trim == $past(trim) + STEP)
                   || (trim == $past(trim) - STEP));

  // R5
  no_wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && at_top) |=> (trim != '0));

  // R5
  no_wrap_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && at_bot) |=> (trim != TRIM_MAX));

  // R5
  err_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_err |-> (at_top || at_bot));

endmodule

// File: rtl/lock_tracker.sv
module lock_tracker
  import osc_trim_pkg::*;
#(
  parameter int TARGET      = 48000,
  parameter int CNT_W       = 17,
  parameter int TOL_PPM     = 2500,
  parameter int LOCK_FRAMES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             meas_valid,
  input  logic [CNT_W-1:0] meas_count,
  output logic             locked
);
  localparam int            TOL    = ppm_span(TARGET, TOL_PPM);
  localparam int            SW     = $clog2(LOCK_FRAMES + 1);
  localparam logic [SW-1:0] FULL_C = SW'(LOCK_FRAMES);

  logic [SW-1:0] streak;
  logic          in_tol;

  assign in_tol = within_tol(int'(meas_count), TARGET, TOL);
  assign locked = (streak == FULL_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streak <= '0;
    end else if (!enable) begin
      streak <= '0;
    end else if (meas_valid) begin
      if (!in_tol)           streak <= '0;
      else if (!locked)      streak <= streak + SW'(1);
    end
  end

  // R8
  unlock_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && !in_tol) |=> !locked);

  // R7
  lock_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(meas_valid) && $past(in_tol));

  // R9
  lock_off_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !locked);

endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl #(
  parameter int TARGET_CNT   = 48000,
  parameter int TRIM_W       = 8,
  parameter int TRIM_INIT    = 128,
  parameter int DEADBAND_PPM = 500,
  parameter int TOL_PPM      = 2500,
  parameter int LOCK_FRAMES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              sof,
  output logic [TRIM_W-1:0] trim_code,
  output logic              locked,
  output logic              trim_err
);
  localparam int CNT_W = $clog2(TARGET_CNT + TARGET_CNT / 2 + 2);

  logic             meas_valid;
  logic [CNT_W-1:0] meas_count;
  logic             timeout_evt;

  sof_interval_counter #(.TARGET(TARGET_CNT), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sof(sof),
    .meas_valid(meas_valid), .meas_count(meas_count),
    .timeout_evt(timeout_evt)
  );

  trim_stepper #(
    .TARGET(TARGET_CNT), .CNT_W(CNT_W), .TRIM_W(TRIM_W),
    .TRIM_INIT(TRIM_INIT), .DEADBAND_PPM(DEADBAND_PPM)
  ) u_step (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .meas_valid(meas_valid), .meas_count(meas_count),
    .trim(trim_code), .sat_err(trim_err)
  );

  lock_tracker #(
    .TARGET(TARGET_CNT), .CNT_W(CNT_W), .TOL_PPM(TOL_PPM),
    .LOCK_FRAMES(LOCK_FRAMES)
  ) u_lock (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .meas_valid(meas_valid), .meas_count(meas_count),
    .locked(locked)
  );

  // R6
  timeout_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> $stable(trim_code) && $stable(locked));

  // R9
  err_off_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !trim_err);

endmodule

// File: tb/osc_trim_ctrl_tb.sv
module osc_trim_ctrl_tb;
  localparam int TGT = 2000;   // deadband 1, tolerance 5, timeout 3000
  localparam int TW  = 4;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, sof = 1'b0;
  logic [TW-1:0] trim_code;
  logic locked, trim_err;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  osc_trim_ctrl #(.TARGET_CNT(TGT), .TRIM_W(TW), .TRIM_INIT(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sof(sof),
    .trim_code(trim_code), .locked(locked), .trim_err(trim_err)
  );

  // interval, expected trim after frame, expected locked
  localparam int VN = 11;
  localparam int V_INT [VN] = '{2000, 2001, 2002, 1998, 1999, 2005, 2006, 1994, 1995, 2100, 3000};
  localparam int V_TRM [VN] = '{8,    8,    7,    8,    8,    7,    6,    7,    8,    7,    6};
  localparam int V_LCK [VN] = '{0,    0,    0,    1,    1,    1,    0,    0,    0,    0,    0};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Next sof pulse lands n cycles after the previous one; returns just after it.
  task automatic frame(input int n);
    repeat (n - 1) @(negedge clk);
    sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
  endtask

  // Behavioural oscillator: counts per ms rise with the code, non-linearly.
  function automatic int osc_count(input int tc);
    return TGT + 2 * (tc - 12) + ((tc >= 14) ? 1 : 0);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 trim", int'(trim_code), 8);
    check("R1 locked", int'(locked), 0);
    check("R1 err", int'(trim_err), 0);
    rst_n = 1'b1; enable = 1'b1;
    @(negedge clk);
    frame(2);                                   // first pulse only arms
    check("R2 arm only", int'(trim_code), 8);

    for (int i = 0; i < VN; i++) begin
      frame(V_INT[i]);
      check($sformatf("R3/R4/R10 vec%0d trim", i), int'(trim_code), V_TRM[i]);
      check($sformatf("R7/R8 vec%0d locked", i), int'(locked), V_LCK[i]);
    end

    frame(3001);                                // discarded, re-arms
    check("R6 timeout trim", int'(trim_code), 6);
    check("R6 timeout locked", int'(locked), 0);
    frame(2002);
    check("R6 restart", int'(trim_code), 5);

    repeat (5) frame(2002);
    check("R5 reach 0", int'(trim_code), 0);
    check("R5 err clear at 0", int'(trim_err), 0);
    frame(2002);
    check("R5 floor hold", int'(trim_code), 0);
    check("R5 err floor", int'(trim_err), 1);
    frame(2000);
    check("R5 err cleared", int'(trim_err), 0);

    repeat (15) frame(1998);
    check("R5 reach max", int'(trim_code), 15);
    check("R5 err at max", int'(trim_err), 0);
    frame(1998);
    check("R5 ceiling hold", int'(trim_code), 15);
    check("R5 err ceiling", int'(trim_err), 1);
    check("R7 locked before disable", int'(locked), 1);

    enable = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 locked off", int'(locked), 0);
    check("R9 err off", int'(trim_err), 0);
    frame(2002); frame(2002);
    check("R9 trim held", int'(trim_code), 15);
    enable = 1'b1;
    frame(2002);
    check("R9 rearm only", int'(trim_code), 15);
    frame(2002);
    check("R9 resumes", int'(trim_code), 14);

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset again", int'(trim_code), 8);
    rst_n = 1'b1;
    frame(2);
    for (int k = 0; k < 10; k++) frame(osc_count(int'(trim_code)));
    check("R3/R4 loop settles", int'(trim_code), 12);
    check("R7 loop locks", int'(locked), 1);
    check("R5 loop no err", int'(trim_err), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule